// File: doc/BRIEF.md
# UART Receive Character Store with Mode-Dependent Error Flags

This block is the back end of a UART receiver. A bit-level front end hands it one character per strobe, together with two check results: whether the parity bit disagreed with the configured parity, and whether a valid stop bit was missing. The block keeps these characters in one of two stores. A control bit selects which store is used. In single mode there is one holding register. In FIFO mode there is a 16-entry queue.

The block keeps sticky error flags, and which flags it keeps depends on the mode. In single mode, parity, framing and overrun errors are recorded in the main status word. In FIFO mode, a full-queue overflow is recorded in the main status word. Parity and framing errors in that mode go to a separate FIFO-status word, which has its own clearing rule. Every flagged error also produces a one-cycle reception-error interrupt pulse.

Software reaches the block through a small register port with four addresses:

- 0: control. bit0 is power, bit1 is receive enable, bit2 is mode (0 single, 1 FIFO).
- 1: receive data.
- 2: main status.
- 3: FIFO status.

Top module: `uart_rx_err_tracker`

## Requirements
- R1: After reset, the control, main status and FIFO-status words read 0, and `rx_err_irq_o` is low.
- R2: A character strobe is ignored unless both power and receive enable are 1. An ignored strobe stores nothing, sets no flag and raises no interrupt.
- R3: In single mode, an accepted character is placed in the holding register. Main status bit4 (data available) then reads 1, and address 1 returns the character. A read strobe at address 1 clears bit4.
- R4: In single mode, a character that arrives while the holding register is still unread sets main status bit2 (overrun), and the new character replaces the old one.
- R5: In FIFO mode, characters are kept in arrival order in a 16-entry queue. Reads at address 1 return them oldest first. FIFO-status bits 6:2 hold the fill count, and main status bit4 reads 1 while the queue is not empty.
- R6: In FIFO mode, a character that arrives while the queue is full and no read frees a slot sets main status bit3 (overflow). The character is dropped, and the queued contents stay unchanged.
- R7: In single mode, a parity error sets main status bit0 and a framing error sets main status bit1.
- R8: In FIFO mode, a parity error sets FIFO-status bit0 and a framing error sets FIFO-status bit1. Main status bits 1:0 are left unchanged.
- R9: `rx_err_irq_o` is high for exactly one cycle for each character that causes any error flag to be set. The pulse comes in the same cycle that the flag first reads set.
- R10: Main status bits 3:0 are sticky. Writing 0 to a bit at address 2 clears that bit, and writing 1 leaves it unchanged. All four bits are cleared once power or receive enable reads 0. A new error that arrives in the same cycle as a clearing write wins.
- R11: FIFO-status bits 1:0 are sticky. They are cleared only while power is 0. Writes to the status registers and clearing receive enable leave them set. Power at 0 also empties both stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| char_valid_i | input | 1 | One-cycle strobe: a character has been received |
| char_data_i | input | DATA_W | Received character |
| char_par_err_i | input | 1 | Parity of the character did not match the configured parity |
| char_frm_err_i | input | 1 | No valid stop bit was seen |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops data at address 1) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| rx_err_irq_o | output | 1 | Reception-error interrupt pulse |

## Verification
A wrong store pointer or a bad fill count shows up at the data port on the first read after it occurs, either as a reordered character or as a character that should have been dropped. A bad count also shows up at once in FIFO-status bits 6:2. A flag routed to the wrong status word, or cleared by the wrong control, is visible in the very next status read. The interrupt is checked in the exact cycle the flag appears, and again one cycle later to confirm the pulse has dropped. Overrun and overflow are driven to their boundary: an unread holding register, and a queue filled to exactly sixteen entries.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;
  localparam logic [1:0] ADDR_FSTAT = 2'd3;

  localparam int CTRL_PWR  = 0;
  localparam int CTRL_RXE  = 1;
  localparam int CTRL_MODE = 2;

  // main status flag positions
  localparam int ST_PAR   = 0;
  localparam int ST_FRM   = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_OVF   = 3;
  localparam int ST_AVAIL = 4;

  localparam int FST_CNT_LSB = 2;

  typedef struct packed {
    logic ovf;
    logic ovr;
    logic frm;
    logic par;
  } stat_t;

  typedef struct packed {
    logic frm;
    logic par;
  } fstat_t;
endpackage

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    data_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_pop, do_push;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full | do_pop);
  assign ovf_o   = push_i & full & ~do_pop;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)) else $error("fifo count above depth"); // R6
  AST_OVF_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flush_i) |=> cnt_q == $past(cnt_q)) else $error("overflow altered fifo"); // R6
endmodule

// File: rtl/urx_hold.sv
module urx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          ovr_o
);
  logic [DW-1:0] data_q;
  logic          valid_q;

  // a read in the same cycle frees the register, so no overrun
  assign ovr_o   = load_i & valid_q & ~rd_i;
  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else begin
      if (load_i) data_q <= data_i;
      if (load_i)    valid_q <= 1'b1;
      else if (rd_i) valid_q <= 1'b0;
    end
  end

  AST_OVR_REPLACES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !flush_i) |=> valid_q && data_q == $past(data_i)) else $error("overrun lost new char"); // R4
endmodule

// File: rtl/urx_status.sv
module urx_status
  import urx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  stat_t  evt_stat_i,
  input  fstat_t evt_fstat_i,
  input  logic   stat_we_i,
  input  stat_t  stat_wmask_i,
  input  logic   clr_stat_i,
  input  logic   clr_fstat_i,
  output stat_t  stat_o,
  output fstat_t fstat_o,
  output logic   irq_o
);
  stat_t  stat_q;
  fstat_t fstat_q;
  logic   irq_q;
  stat_t  keep;

  assign keep = stat_we_i ? stat_wmask_i : stat_t'('1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      fstat_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      // new errors win over a same-cycle clearing write
      stat_q  <= clr_stat_i  ? stat_t'('0)  : ((stat_q & keep) | evt_stat_i);
      fstat_q <= clr_fstat_i ? fstat_t'('0) : (fstat_q | evt_fstat_i);
      irq_q   <= (|evt_stat_i) | (|evt_fstat_i);
    end
  end

  assign stat_o  = stat_q;
  assign fstat_o = fstat_q;
  assign irq_o   = irq_q;

  AST_IRQ_ON_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat_q.par) || $rose(stat_q.frm) || $rose(stat_q.ovr) || $rose(stat_q.ovf)) |-> irq_q)
    else $error("status flag set without irq"); // R9
  AST_IRQ_ON_FSTAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fstat_q.par) || $rose(fstat_q.frm)) |-> irq_q) else $error("fifo flag set without irq"); // R9
endmodule

// File: rtl/uart_rx_err_tracker.sv
module uart_rx_err_tracker
  import urx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_par_err_i,
  input  logic              char_frm_err_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rx_err_irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic pwr_q, rxe_q, mode_q;
  logic accept, data_rd, flush;
  logic [DATA_W-1:0] hold_data, fifo_data;
  logic hold_valid, hold_ovr, fifo_empty, fifo_ovf;
  logic [CNT_W-1:0] fifo_cnt;
  stat_t  evt_stat, stat, wmask;
  fstat_t evt_fstat, fstat;
  logic   avail;
  logic   unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= 1'b0;
      rxe_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (reg_wr_i && reg_addr_i == ADDR_CTRL) begin
      pwr_q  <= reg_wdata_i[CTRL_PWR];
      rxe_q  <= reg_wdata_i[CTRL_RXE];
      mode_q <= reg_wdata_i[CTRL_MODE];
    end
  end

  assign accept  = char_valid_i & pwr_q & rxe_q;
  assign data_rd = reg_rd_i & (reg_addr_i == ADDR_DATA);
  assign flush   = ~pwr_q;

  urx_hold #(.DW(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .load_i  (accept & ~mode_q),
    .data_i  (char_data_i),
    .rd_i    (data_rd & ~mode_q),
    .data_o  (hold_data),
    .valid_o (hold_valid),
    .ovr_o   (hold_ovr)
  );

  urx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (accept & mode_q),
    .data_i  (char_data_i),
    .pop_i   (data_rd & mode_q),
    .data_o  (fifo_data),
    .empty_o (fifo_empty),
    .ovf_o   (fifo_ovf),
    .count_o (fifo_cnt)
  );

  always_comb begin
    evt_stat     = '0;
    evt_fstat    = '0;
    evt_stat.par = accept & ~mode_q & char_par_err_i;
    evt_stat.frm = accept & ~mode_q & char_frm_err_i;
    evt_stat.ovr = hold_ovr;
    evt_stat.ovf = fifo_ovf;
    evt_fstat.par = accept & mode_q & char_par_err_i;
    evt_fstat.frm = accept & mode_q & char_frm_err_i;
  end

  assign wmask = stat_t'(reg_wdata_i[ST_OVF:ST_PAR]);

  urx_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_stat_i   (evt_stat),
    .evt_fstat_i  (evt_fstat),
    .stat_we_i    (reg_wr_i && reg_addr_i == ADDR_STAT),
    .stat_wmask_i (wmask),
    .clr_stat_i   (~(pwr_q & rxe_q)),
    .clr_fstat_i  (~pwr_q),
    .stat_o       (stat),
    .fstat_o      (fstat),
    .irq_o        (rx_err_irq_o)
  );

  assign avail = mode_q ? ~fifo_empty : hold_valid;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[CTRL_PWR]  = pwr_q;
        reg_rdata_o[CTRL_RXE]  = rxe_q;
        reg_rdata_o[CTRL_MODE] = mode_q;
      end
      ADDR_DATA: if (avail) reg_rdata_o = mode_q ? fifo_data : hold_data;
      ADDR_STAT: begin
        reg_rdata_o[ST_OVF:ST_PAR] = stat;
        reg_rdata_o[ST_AVAIL]      = avail;
      end
      default: begin
        reg_rdata_o[1:0] = fstat;
        reg_rdata_o[FST_CNT_LSB +: CNT_W] = fifo_cnt;
      end
    endcase
  end

  AST_STAT_CLR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_q && rxe_q) |=> stat == '0) else $error("status kept while disabled"); // R10
  AST_FSTAT_CLR_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q |=> fstat == '0 && fifo_empty && !hold_valid) else $error("power off kept state"); // R11
  AST_IGNORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !(pwr_q && rxe_q)) |=> !rx_err_irq_o) else $error("ignored char raised irq"); // R2
  AST_SINGLE_NO_FSTAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && pwr_q && $stable(mode_q)) |=> $stable(fstat)) else $error("single mode touched fifo flags"); // R8
endmodule

// File: tb/uart_rx_err_tracker_tb.sv
module uart_rx_err_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cv = 1'b0, cpar = 1'b0, cfrm = 1'b0;
  logic [DW-1:0] cdata = '0;
  logic [1:0]    addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            n_chk = 0, n_fail = 0;
  logic          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_err_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .char_valid_i(cv), .char_data_i(cdata), .char_par_err_i(cpar), .char_frm_err_i(cfrm),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rx_err_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pop(output logic [DW-1:0] d);
    @(negedge clk); addr = 2'd1; rd = 1'b1; #1; d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // leaves the clock at the negedge where flags and irq are visible
  task automatic send(input logic [DW-1:0] d, input logic p, input logic f);
    @(negedge clk); cv = 1'b1; cdata = d; cpar = p; cfrm = f;
    @(negedge clk); cv = 1'b0; cpar = 1'b0; cfrm = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 irq", irq, 0);
    peek(2'd0, v); check("R1 ctrl", v, 0);
    peek(2'd2, v); check("R1 stat", v, 0);
    peek(2'd3, v); check("R1 fstat", v, 0);
  endtask

  task automatic t_ignored();
    logic [DW-1:0] v;
    reg_write(2'd0, 8'h01);
    send(8'hA5, 1'b1, 1'b1);
    check("R2 irq rxe off", irq, 0);
    peek(2'd2, v); check("R2 stat rxe off", v, 0);
    reg_write(2'd0, 8'h02);
    send(8'hA5, 1'b1, 1'b0);
    check("R2 irq pwr off", irq, 0);
    peek(2'd2, v); check("R2 stat pwr off", v, 0);
  endtask

  task automatic t_single();
    logic [DW-1:0] v;
    reg_write(2'd0, 8'h03);
    send(8'h5A, 1'b0, 1'b0);
    check("R3 irq clean char", irq, 0);
    peek(2'd2, v); check("R3 avail", v, 8'h10);
    pop(v); check("R3 data", v, 8'h5A);
    peek(2'd2, v); check("R3 avail cleared", v, 8'h00);
  endtask

  task automatic t_overrun();
    logic [DW-1:0] v;
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0);
    check("R9 irq on overrun", irq, 1);
    @(negedge clk); check("R9 irq one cycle", irq, 0);
    peek(2'd2, v); check("R4 overrun flag", v, 8'h14);
    pop(v); check("R4 data replaced", v, 8'h22);
  endtask

  task automatic t_single_err();
    logic [DW-1:0] v;
    send(8'h33, 1'b1, 1'b0);
    check("R9 irq parity", irq, 1);
    peek(2'd2, v); check("R7 parity flag", v, 8'h15);
    send(8'h44, 1'b0, 1'b1);
    peek(2'd2, v); check("R7 framing+overrun", v, 8'h17);
    peek(2'd3, v); check("R8 fstat untouched in single", v, 0);
    reg_write(2'd2, 8'h1E);
    peek(2'd2, v); check("R10 clear parity only", v, 8'h16);
    reg_write(2'd2, 8'h1F);
    peek(2'd2, v); check("R10 write one keeps", v, 8'h16);
    pop(v);
    send(8'h55, 1'b1, 1'b0);
    check("R9 irq first repeat", irq, 1);
    pop(v);
    send(8'h56, 1'b1, 1'b0);
    check("R9 irq second repeat", irq, 1);
    peek(2'd2, v); check("R10 sticky parity", v[3:0], 4'h7);
    reg_write(2'd0, 8'h01);
    peek(2'd2, v); check("R10 rxe clear", v[3:0], 0);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_fifo();
    logic [DW-1:0] v;
    reg_write(2'd0, 8'h07);
    for (int i = 0; i < 16; i++) send(DW'(i * 3 + 1), 1'b0, 1'b0);
    peek(2'd3, v); check("R5 count full", v, 8'h40);
    peek(2'd2, v); check("R5 avail", v, 8'h10);
    send(8'hEE, 1'b0, 1'b0);
    check("R9 irq overflow", irq, 1);
    peek(2'd2, v); check("R6 overflow flag", v, 8'h18);
    peek(2'd3, v); check("R6 count kept", v, 8'h40);
    for (int i = 0; i < 16; i++) begin
      pop(v); check("R5 order", v, DW'(i * 3 + 1));
    end
    peek(2'd2, v); check("R6 dropped char absent", v, 8'h08);
  endtask

  task automatic t_fifo_err();
    logic [DW-1:0] v;
    send(8'h61, 1'b1, 1'b0);
    check("R9 irq fifo parity", irq, 1);
    peek(2'd3, v); check("R8 fifo parity", v, 8'h05);
    peek(2'd2, v); check("R8 main par/frm clear", v, 8'h18);
    send(8'h62, 1'b0, 1'b1);
    peek(2'd3, v); check("R8 fifo framing", v, 8'h0B);
    reg_write(2'd2, 8'h00);
    peek(2'd2, v); check("R10 ovf cleared", v, 8'h10);
    peek(2'd3, v); check("R11 stat write keeps fstat", v, 8'h0B);
    reg_write(2'd0, 8'h05);
    peek(2'd3, v); check("R11 rxe off keeps fstat", v, 8'h0B);
    reg_write(2'd0, 8'h04);
    peek(2'd3, v); check("R11 pwr off clears fstat", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ignored();
    t_single();
    t_overrun();
    t_single_err();
    t_fifo();
    t_fifo_err();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule